// File: doc/BRIEF.md
# Duplicate-Rejecting Population Update Chain

This block keeps the fitness picture of a multi-objective evolutionary search population and decides, for each freshly evaluated offspring, which population slot (if any) the offspring should land in. It is a linear pipeline with one cell per population slot. Each cell holds its slot's fitness vector and a "free" mark that flags the slot as a redundant copy of another member. Offspring records enter at cell 0 and move one cell per clock. Each record carries its fitness vector, chromosome, a selected bit from the upstream selection stage, a target slot address, and a found bit. The found bit is clear on entry. Whatever leaves the final cell is dropped.

Two individuals count as identical when their fitness vectors are equal; chromosomes are never compared. A selected offspring replaces its target slot unless an identical member already sits earlier in the chain. An offspring that is not selected may still take over a slot already marked redundant, unless that slot dominates it. Once a record has been placed or matched, every later slot with the same fitness is marked redundant. When a slot is overwritten, the cell raises a one-cycle write strobe on that slot's own lane, with the offspring chromosome and fitness, toward the population memory (which is outside the block).

Top module: `dup_reject_chain`

## Requirements
- R1: While `rst_n` is low, no write strobe is raised. A synchronous `init_i` pulse does three things: it loads slot k's fitness from `init_fit_i[k*VEC_W +: VEC_W]`, it clears every free mark, and it discards every record in flight, so that no write results from those records.
- R2: Suppose a record is sampled with `rec_valid_i` at clock edge E. Then slot k judges it at edge E+k, and any write it causes at slot k is shown on lane k (`wr_en_o[k]`, `wr_fit_o[k*VEC_W +: VEC_W]`, `wr_chrom_o[k*CHROM_W +: CHROM_W]`) for exactly the cycle after that edge.
- R3: A selected record whose found bit is still clear, on reaching the slot whose index equals its target, overwrites that slot's fitness, raises that slot's write strobe and sets found. Within a fitness vector, objective o sits at bits `[o*FIT_W +: FIT_W]`.
- R4: A record whose found bit is clear, at a slot that is not its selected target and whose fitness equals the record's on every objective, sets found without writing. The record then causes no write anywhere.
- R5: A record whose found bit is set, on passing a slot with equal fitness, sets that slot's free mark. It makes no write.
- R6: A record whose found bit is clear, at a free slot whose index differs from the record's target and whose fitness does not dominate the record's, overwrites the slot, raises the strobe, sets found and clears that slot's free mark.
- R7: A free slot whose fitness dominates the record's keeps its contents, and the record moves on.
- R8: A record causes at most one write. A record that finds no target, no match and no usable free slot causes no write and is dropped after the last cell.
- R9: Slot A dominates record B when every objective of A is greater than or equal to B's and at least one is strictly greater. Two mutually non-dominating vectors therefore allow reuse of a free slot.
- R10: Records follow one another back to back, one per cycle. Each record is judged at slot k against that slot's state as left by all earlier records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Load start-up fitness, clear free marks, flush records |
| init_fit_i | input | NUM_SLOTS*VEC_W | Start-up fitness of every slot, slot k at k*VEC_W |
| rec_valid_i | input | 1 | Offspring record present |
| rec_fit_i | input | VEC_W | Offspring fitness vector |
| rec_chrom_i | input | CHROM_W | Offspring chromosome |
| rec_sel_i | input | 1 | Offspring chosen to replace its target parent |
| rec_tgt_i | input | ADDR_W | Target parent slot address |
| wr_en_o | output | NUM_SLOTS | Per-slot one-cycle write strobe |
| wr_fit_o | output | NUM_SLOTS*VEC_W | Fitness to write, lane k at k*VEC_W |
| wr_chrom_o | output | NUM_SLOTS*CHROM_W | Chromosome to write, lane k at k*CHROM_W |

## Verification
Because several records are in flight at once, one slot can be marked redundant by one record in the same cycle that a later slot is overwritten by the record right behind it. A third record that arrives two cycles later must then reuse the freshly marked slot. The bench provokes this by sending three records back to back. A reference model processes the records one after another and predicts the lane and cycle of every write. A scoreboard then matches each strobe against those predictions and flags any write that is missing, unexpected or carries the wrong data.

// File: rtl/dr_pkg.sv
package dr_pkg;

    // Decision a cell takes on the record it currently sees
    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,  // no record
        ACT_TARGET = 3'd1,  // selected record reaches its parent slot
        ACT_MATCH  = 3'd2,  // identical member found, suppress insertion
        ACT_REUSE  = 3'd3,  // redundant slot taken over by the record
        ACT_MARK   = 3'd4,  // already placed record flags this slot redundant
        ACT_PASS   = 3'd5   // nothing to do here
    } cell_act_e;

endpackage

// File: rtl/dr_fit_cmp.sv
module dr_fit_cmp #(
    parameter int NUM_OBJ = 2,
    parameter int FIT_W   = 8
) (
    input  logic [NUM_OBJ*FIT_W-1:0] slot_fit,
    input  logic [NUM_OBJ*FIT_W-1:0] rec_fit,
    output logic                     equal,
    output logic                     slot_dom
);
    logic [NUM_OBJ-1:0] ge_v;
    logic [NUM_OBJ-1:0] gt_v;
    logic [NUM_OBJ-1:0] eq_v;

    // one comparator triple per objective
    for (genvar o = 0; o < NUM_OBJ; o++) begin : g_obj
        logic [FIT_W-1:0] s_val;
        logic [FIT_W-1:0] r_val;
        assign s_val   = slot_fit[o*FIT_W +: FIT_W];
        assign r_val   = rec_fit[o*FIT_W +: FIT_W];
        assign ge_v[o] = (s_val >= r_val);
        assign gt_v[o] = (s_val >  r_val);
        assign eq_v[o] = (s_val == r_val);
    end

    assign equal    = &eq_v;
    assign slot_dom = (&ge_v) && (|gt_v);

endmodule

// File: rtl/dr_cell.sv
module dr_cell
    import dr_pkg::*;
#(
    parameter int NUM_OBJ = 2,
    parameter int FIT_W   = 8,
    parameter int CHROM_W = 16,
    parameter int ADDR_W  = 2,
    parameter int SLOT_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_i,
    input  logic [NUM_OBJ*FIT_W-1:0] init_fit_i,
    input  logic                     in_valid,
    input  logic [NUM_OBJ*FIT_W-1:0] in_fit,
    input  logic [CHROM_W-1:0]       in_chrom,
    input  logic                     in_sel,
    input  logic [ADDR_W-1:0]        in_tgt,
    input  logic                     in_found,
    output logic                     out_valid,
    output logic [NUM_OBJ*FIT_W-1:0] out_fit,
    output logic [CHROM_W-1:0]       out_chrom,
    output logic                     out_sel,
    output logic [ADDR_W-1:0]        out_tgt,
    output logic                     out_found,
    output logic                     wr_o
);
    localparam int VEC_W = NUM_OBJ * FIT_W;
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SLOT_ID);

    typedef struct packed {
        logic [VEC_W-1:0]   fit;     // slot fitness
        logic               free;    // slot is a redundant copy
        logic               rvalid;  // forwarded record
        logic [VEC_W-1:0]   rfit;
        logic [CHROM_W-1:0] rchrom;
        logic               rsel;
        logic [ADDR_W-1:0]  rtgt;
        logic               rfound;
        logic               wr;      // slot overwritten on this edge
    } cell_t;

    cell_t     cell_d, cell_q;
    cell_act_e act;
    logic      equal;
    logic      slot_dom;
    logic      is_tgt;

    dr_fit_cmp #(
        .NUM_OBJ (NUM_OBJ),
        .FIT_W   (FIT_W)
    ) u_cmp (
        .slot_fit (cell_q.fit),
        .rec_fit  (in_fit),
        .equal    (equal),
        .slot_dom (slot_dom)
    );

    assign is_tgt = in_sel && (in_tgt == MY_ADDR);

    // classify what this slot does with the incoming record
    always_comb begin
        if (!in_valid) begin
            act = ACT_IDLE;
        end else if (in_found) begin
            act = equal ? ACT_MARK : ACT_PASS;
        end else if (is_tgt) begin
            act = ACT_TARGET;
        end else if (equal) begin
            act = ACT_MATCH;
        end else if (cell_q.free && (in_tgt != MY_ADDR) && !slot_dom) begin
            act = ACT_REUSE;
        end else begin
            act = ACT_PASS;
        end
    end

    always_comb begin
        cell_d        = cell_q;
        cell_d.rvalid = in_valid;
        cell_d.rfit   = in_fit;
        cell_d.rchrom = in_chrom;
        cell_d.rsel   = in_sel;
        cell_d.rtgt   = in_tgt;
        cell_d.rfound = in_found;
        cell_d.wr     = 1'b0;
        unique case (act)
            ACT_TARGET: begin
                cell_d.fit    = in_fit;
                cell_d.rfound = 1'b1;
                cell_d.wr     = 1'b1;
            end
            ACT_MATCH: begin
                cell_d.rfound = 1'b1;
            end
            ACT_REUSE: begin
                cell_d.fit    = in_fit;
                cell_d.free   = 1'b0;
                cell_d.rfound = 1'b1;
                cell_d.wr     = 1'b1;
            end
            ACT_MARK: begin
                cell_d.free = 1'b1;
            end
            default: begin
            end
        endcase
        if (init_i) begin
            cell_d.fit    = init_fit_i;
            cell_d.free   = 1'b0;
            cell_d.rvalid = 1'b0;
            cell_d.wr     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign out_valid = cell_q.rvalid;
    assign out_fit   = cell_q.rfit;
    assign out_chrom = cell_q.rchrom;
    assign out_sel   = cell_q.rsel;
    assign out_tgt   = cell_q.rtgt;
    assign out_found = cell_q.rfound;
    assign wr_o      = cell_q.wr;

    // R2: a record accepted here appears at the output one cycle later
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !init_i) |=> out_valid);

    // R1: init leaves the cell quiet on the next cycle
    a_r1_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!wr_o && !out_valid));

    // R3: a selected, unplaced record writes its target slot
    a_r3_target_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_found && !init_i && is_tgt) |=> (wr_o && out_found));

    // R4: an identical member suppresses the write but marks the record placed
    a_r4_match_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_found && !init_i && !is_tgt && equal) |=> (!wr_o && out_found));

    // R8: a placed record never writes again and stays placed
    a_r8_found_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_found && !init_i) |=> (!wr_o && out_found));

    // R7: a dominating slot is never taken over by a non-target record
    a_r7_no_dominated_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_found && !init_i && !is_tgt && slot_dom) |=> !wr_o);

endmodule

// File: rtl/dup_reject_chain.sv
module dup_reject_chain #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_OBJ   = 2,
    parameter int FIT_W     = 8,
    parameter int CHROM_W   = 16,
    localparam int ADDR_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int VEC_W    = NUM_OBJ * FIT_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           init_i,
    input  logic [NUM_SLOTS*VEC_W-1:0]     init_fit_i,
    input  logic                           rec_valid_i,
    input  logic [VEC_W-1:0]               rec_fit_i,
    input  logic [CHROM_W-1:0]             rec_chrom_i,
    input  logic                           rec_sel_i,
    input  logic [ADDR_W-1:0]              rec_tgt_i,
    output logic [NUM_SLOTS-1:0]           wr_en_o,
    output logic [NUM_SLOTS*VEC_W-1:0]     wr_fit_o,
    output logic [NUM_SLOTS*CHROM_W-1:0]   wr_chrom_o
);
    // record link leaving each cell
    logic               lk_valid [NUM_SLOTS];
    logic [VEC_W-1:0]   lk_fit   [NUM_SLOTS];
    logic [CHROM_W-1:0] lk_chrom [NUM_SLOTS];
    logic               lk_sel   [NUM_SLOTS];
    logic [ADDR_W-1:0]  lk_tgt   [NUM_SLOTS];
    logic               lk_found [NUM_SLOTS];

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_cell
        logic               src_valid;
        logic [VEC_W-1:0]   src_fit;
        logic [CHROM_W-1:0] src_chrom;
        logic               src_sel;
        logic [ADDR_W-1:0]  src_tgt;
        logic               src_found;

        if (k == 0) begin : g_head
            assign src_valid = rec_valid_i;
            assign src_fit   = rec_fit_i;
            assign src_chrom = rec_chrom_i;
            assign src_sel   = rec_sel_i;
            assign src_tgt   = rec_tgt_i;
            assign src_found = 1'b0;
        end else begin : g_link
            assign src_valid = lk_valid[k-1];
            assign src_fit   = lk_fit[k-1];
            assign src_chrom = lk_chrom[k-1];
            assign src_sel   = lk_sel[k-1];
            assign src_tgt   = lk_tgt[k-1];
            assign src_found = lk_found[k-1];
        end

        dr_cell #(
            .NUM_OBJ (NUM_OBJ),
            .FIT_W   (FIT_W),
            .CHROM_W (CHROM_W),
            .ADDR_W  (ADDR_W),
            .SLOT_ID (k)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_i     (init_i),
            .init_fit_i (init_fit_i[k*VEC_W +: VEC_W]),
            .in_valid   (src_valid),
            .in_fit     (src_fit),
            .in_chrom   (src_chrom),
            .in_sel     (src_sel),
            .in_tgt     (src_tgt),
            .in_found   (src_found),
            .out_valid  (lk_valid[k]),
            .out_fit    (lk_fit[k]),
            .out_chrom  (lk_chrom[k]),
            .out_sel    (lk_sel[k]),
            .out_tgt    (lk_tgt[k]),
            .out_found  (lk_found[k]),
            .wr_o       (wr_en_o[k])
        );

        // write data is the record held in the cell's output stage
        assign wr_fit_o[k*VEC_W +: VEC_W]       = lk_fit[k];
        assign wr_chrom_o[k*CHROM_W +: CHROM_W] = lk_chrom[k];
    end

    // R2: the head lane can only fire for a record sampled on the previous edge
    a_r2_head_source: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o[0] |-> $past(rec_valid_i && !init_i));

    // R8: a record leaving the tail unplaced never wrote on the way
    a_r8_tail_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid[NUM_SLOTS-1] && !lk_found[NUM_SLOTS-1]) |-> !wr_en_o[NUM_SLOTS-1]);

endmodule

// File: tb/dup_reject_chain_test.sv
module dup_reject_chain_test;

    localparam int P  = 4;
    localparam int NO = 2;
    localparam int FW = 8;
    localparam int CW = 16;
    localparam int VW = NO * FW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            init_i = 1'b0;
    logic [P*VW-1:0] init_fit_i;
    logic            rec_valid_i = 1'b0;
    logic [VW-1:0]   rec_fit_i = '0;
    logic [CW-1:0]   rec_chrom_i = '0;
    logic            rec_sel_i = 1'b0;
    logic [1:0]      rec_tgt_i = '0;
    logic [P-1:0]    wr_en_o;
    logic [P*VW-1:0] wr_fit_o;
    logic [P*CW-1:0] wr_chrom_o;

    always #4 clk = ~clk;  // 125 MHz

    dup_reject_chain #(
        .NUM_SLOTS (P),
        .NUM_OBJ   (NO),
        .FIT_W     (FW),
        .CHROM_W   (CW)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .init_fit_i  (init_fit_i),
        .rec_valid_i (rec_valid_i),
        .rec_fit_i   (rec_fit_i),
        .rec_chrom_i (rec_chrom_i),
        .rec_sel_i   (rec_sel_i),
        .rec_tgt_i   (rec_tgt_i),
        .wr_en_o     (wr_en_o),
        .wr_fit_o    (wr_fit_o),
        .wr_chrom_o  (wr_chrom_o)
    );

    typedef struct {
        int            due;
        int            lane;
        logic [CW-1:0] chrom;
        logic [VW-1:0] fit;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [VW-1:0] mfit [P];
    logic          mfree [P];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            unexp = 0;
    int            mark = 0;
    bit            done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic bit dominates(input logic [VW-1:0] a, input logic [VW-1:0] b);
        bit all_ge = 1'b1;
        bit any_gt = 1'b0;
        for (int o = 0; o < NO; o++) begin
            if (a[o*FW +: FW] < b[o*FW +: FW]) all_ge = 1'b0;
            if (a[o*FW +: FW] > b[o*FW +: FW]) any_gt = 1'b1;
        end
        return all_ge && any_gt;
    endfunction

    function automatic logic [P*VW-1:0] start_vec();
        // slot0 (10,10) slot1 (20,5) slot2 (5,20) slot3 (15,15); objective 0 in low byte
        return {8'd15, 8'd15, 8'd20, 8'd5, 8'd5, 8'd20, 8'd10, 8'd10};
    endfunction

    // reference model: walk the slots in order, predict writes (R2..R10)
    task automatic model(input logic [VW-1:0] fv, input logic [CW-1:0] ch,
                         input bit sel, input int tgt, input string tag, input int base);
        bit found = 1'b0;
        for (int k = 0; k < P; k++) begin
            bit wr = 1'b0;
            if (found) begin
                if (mfit[k] == fv) mfree[k] = 1'b1;
            end else if (sel && tgt == k) begin
                mfit[k] = fv; found = 1'b1; wr = 1'b1;
            end else if (mfit[k] == fv) begin
                found = 1'b1;
            end else if (mfree[k] && tgt != k && !dominates(mfit[k], fv)) begin
                mfit[k] = fv; mfree[k] = 1'b0; found = 1'b1; wr = 1'b1;
            end
            if (wr) begin
                exp_t e;
                e.due = base + k; e.lane = k; e.chrom = ch; e.fit = fv; e.tag = tag;
                sb.push_back(e);
            end
        end
    endtask

    task automatic send(input logic [7:0] f0, input logic [7:0] f1, input logic [CW-1:0] ch,
                        input bit sel, input int tgt, input string tag, input bit modeled);
        @(negedge clk);
        rec_valid_i = 1'b1;
        rec_fit_i   = {f1, f0};
        rec_chrom_i = ch;
        rec_sel_i   = sel;
        rec_tgt_i   = tgt[1:0];
        if (modeled) model({f1, f0}, ch, sel, tgt, tag, cyc + 1);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rec_valid_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_init();
        @(negedge clk);
        rec_valid_i = 1'b0;
        init_i = 1'b1;
        for (int k = 0; k < P; k++) begin
            mfit[k]  = init_fit_i[k*VW +: VW];
            mfree[k] = 1'b0;
        end
        @(negedge clk);
        init_i = 1'b0;
    endtask

    task automatic quiet(input string tag);
        check(unexp == mark && sb.size() == 0, tag,
              $sformatf("unexpected writes actual=%0d expected=0", unexp - mark));
        mark = unexp;
    endtask

    // monitor: match every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int k = 0; k < P; k++) begin
                if (wr_en_o[k]) begin
                    int hit = -1;
                    for (int i = 0; i < sb.size(); i++)
                        if (hit < 0 && sb[i].due == cyc && sb[i].lane == k) hit = i;
                    if (hit < 0) begin
                        unexp++;
                        check(1'b0, "R8", $sformatf("lane %0d cycle %0d actual=write expected=none",
                                                    k, cyc));
                    end else begin
                        check(wr_fit_o[k*VW +: VW] == sb[hit].fit &&
                              wr_chrom_o[k*CW +: CW] == sb[hit].chrom, sb[hit].tag,
                              $sformatf("lane %0d actual=%h/%h expected=%h/%h", k,
                                        wr_fit_o[k*VW +: VW], wr_chrom_o[k*CW +: CW],
                                        sb[hit].fit, sb[hit].chrom));
                        sb.delete(hit);
                    end
                end
            end
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].due <= cyc) begin
                    check(1'b0, sb[i].tag, $sformatf("lane %0d actual=no write expected=write at %0d",
                                                     sb[i].lane, sb[i].due));
                    sb.delete(i);
                end
            end
        end
    end

    initial begin
        init_fit_i = start_vec();
        repeat (3) @(negedge clk);
        check(wr_en_o == '0, "R1", $sformatf("reset strobes actual=%b expected=0", wr_en_o));
        rst_n = 1'b1;
        do_init();

        // R3: selected record replaces its target slot 2
        send(30, 30, 16'hA001, 1'b1, 2, "R3", 1'b1);
        idle(P + 2);
        // R4/R10: same fitness as slot1, different chromosome: no insertion
        mark = unexp;
        send(20, 5, 16'hBEEF, 1'b0, 0, "R4", 1'b1);
        idle(P + 2);
        quiet("R4");
        // R5: placing (15,15) at slot0 marks slot3 redundant, then R6/R9 reuse it
        send(15, 15, 16'hA002, 1'b1, 0, "R5", 1'b1);
        idle(P + 2);
        send(16, 1, 16'hA003, 1'b0, 0, "R6", 1'b1);
        idle(P + 2);
        // R6: free mark was cleared, so no second reuse
        mark = unexp;
        send(17, 2, 16'hA004, 1'b0, 0, "R6", 1'b1);
        idle(P + 2);
        quiet("R6");
        // mark slot3 again, then R7: dominated offspring leaves it untouched
        send(16, 1, 16'hA005, 1'b1, 1, "R5", 1'b1);
        idle(P + 2);
        mark = unexp;
        send(4, 1, 16'hA006, 1'b0, 0, "R7", 1'b1);
        idle(P + 2);
        quiet("R7");
        // R9: incomparable offspring takes the free slot
        send(2, 9, 16'hA007, 1'b0, 0, "R9", 1'b1);
        idle(P + 2);
        // R8: nothing to do, record is dropped
        mark = unexp;
        send(1, 1, 16'hA008, 1'b0, 0, "R8", 1'b1);
        idle(P + 2);
        quiet("R8");
        // R8: target lies after an identical member
        send(30, 30, 16'hA009, 1'b1, 3, "R8", 1'b1);
        idle(P + 2);
        quiet("R8");
        // R10: back-to-back; second record matches what the first just wrote
        send(40, 1, 16'hA00A, 1'b1, 0, "R10", 1'b1);
        send(40, 1, 16'hA00B, 1'b1, 1, "R10", 1'b1);
        idle(P + 2);
        // R10: mark of slot3 and write of slot2 fall in one cycle, third record reuses slot3
        send(2, 9, 16'hA00C, 1'b1, 1, "R10", 1'b1);
        send(60, 60, 16'hA00D, 1'b1, 2, "R10", 1'b1);
        send(3, 3, 16'hA00E, 1'b0, 0, "R10", 1'b1);
        idle(P + 2);
        // R1: init flushes a record in flight
        mark = unexp;
        send(77, 77, 16'hA00F, 1'b1, 3, "R1", 1'b0);
        do_init();
        idle(P + 2);
        quiet("R1");
        // R1: start-up fitness reloaded, slot1 (20,5) matches again
        send(20, 5, 16'hA010, 1'b1, 3, "R1", 1'b1);
        idle(P + 2);
        quiet("R1");
        check(n_chk >= 12, "R2", $sformatf("checks actual=%0d expected>=12", n_chk));
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2: watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule